// File: doc/BRIEF.md
# Overlapped Register Window File

This block is a register file of 74 physical entries that a procedure sees as 32 logical registers. The logical numbers split into four groups: R0-R9 are global and map to the same physical cells in every window, R10-R15 are the incoming registers shared with the caller, R16-R25 are the procedure's private locals, and R26-R31 are the outgoing registers shared with the callee. Four windows sit on a ring of 64 physical cells, each 16 cells past the previous one. The callee's incoming group is therefore the same storage as the caller's outgoing group, and arguments pass without any copy.

A call advances the current window pointer and a return moves it back, both modulo 4. A small controller counts the nesting depth. A call that would need a fifth window is refused and raises the overflow flag. A return with no open call is refused and raises the underflow flag. Saving and restoring windows to memory is left to the software that services these flags.

The controller has three states. WIN_ROOT is depth 0. WIN_NESTED covers depths from 1 up to one below the last window. WIN_FULL is the deepest window. There are three kinds of transition. A descend is an accepted call: WIN_ROOT to WIN_NESTED (or to WIN_FULL when there are only two windows), WIN_NESTED to WIN_NESTED, or WIN_NESTED to WIN_FULL. An ascend is an accepted return: WIN_FULL or WIN_NESTED to WIN_NESTED, or to WIN_ROOT when depth reaches 0. A reject is a call in WIN_FULL or a return in WIN_ROOT; the state stays where it is and a flag is raised.

Top module: `regwin_file`

## Requirements
- R1: After reset, every logical register reads zero in every window, the window pointer and depth are 0, and both flags are low.
- R2: Logical R1-R9 address the same physical registers whatever the current window is.
- R3: For logical r of 10 or above, the physical index is 10 + ((cwp*16 + r - 10) mod 64). As a result, the callee's R10-R15 are the caller's R26-R31.
- R4: Locals R16-R25 of one window are not visible in any other window.
- R5: Logical R0 always reads zero on both read ports, and a write to R0 changes nothing.
- R6: The outgoing registers R26-R31 of window 3 are the incoming registers R10-R15 of window 0.
- R7: An accepted call advances cwp by 1 modulo 4 and raises depth by 1. An accepted return moves cwp back by 1 modulo 4 and lowers depth by 1.
- R8: A call at depth 3 leaves cwp and depth unchanged. The overflow flag is high for exactly the one cycle after that edge.
- R9: A return at depth 0 leaves cwp and depth unchanged. The underflow flag is high for exactly the one cycle after that edge.
- R10: A write on the same edge as a call or return goes through the window in effect before that edge.
- R11: When call and return are asserted together, cwp and depth stay unchanged and neither flag is raised.
- R12: Both read ports are combinational and independent, and each returns the value last written to the physical register it maps to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_a | input | 5 | Logical register number, read port A |
| rd_data_a | output | 32 | Read data, port A (combinational) |
| rd_addr_b | input | 5 | Logical register number, read port B |
| rd_data_b | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register number for the write |
| wr_data | input | 32 | Write data |
| call_req | input | 1 | Open a new window on this edge |
| ret_req | input | 1 | Close the current window on this edge |
| overflow | output | 1 | One-cycle pulse: a call was refused |
| underflow | output | 1 | One-cycle pulse: a return was refused |

## Verification
The bench builds the block with its default parameters: 10 globals, 10 locals, 6 shared registers, 4 windows and 32-bit data. With four windows the overflow boundary is only three calls deep, so the bench reaches the refused call, the wrap of window 3's outgoing group onto window 0's incoming group, and the refused return at the root within a few dozen cycles. A long random phase then mixes calls, returns and writes to all 32 logical numbers, so every one of the 74 physical cells and every state transition is exercised many times against the behavioural model.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

    // Nesting state of the window controller
    typedef enum logic [1:0] {
        WIN_ROOT   = 2'd0,   // depth 0, no open call
        WIN_NESTED = 2'd1,   // 0 < depth < windows-1
        WIN_FULL   = 2'd2    // deepest window in use
    } win_state_e;

endpackage

// File: rtl/rwf_addr_map.sv
// Logical-to-physical register number translation for one port.
module rwf_addr_map #(
    parameter int NGLOB   = 10,
    parameter int NLOCAL  = 10,
    parameter int NCOMMON = 6,
    parameter int NWIN    = 4,
    parameter int LAW     = 5,
    parameter int PAW     = 7,
    parameter int CWPW    = 2
) (
    input  logic [LAW-1:0]  log_addr,
    input  logic [CWPW-1:0] cwp,
    output logic [PAW-1:0]  phys_addr
);
    localparam int STRIDE = NLOCAL + NCOMMON;
    localparam int RING   = STRIDE * NWIN;

    int lin;

    always_comb begin
        lin = int'(cwp) * STRIDE + int'(log_addr) - NGLOB;
        if (lin >= RING) begin
            lin = lin - RING;
        end
        if (int'(log_addr) < NGLOB) begin
            phys_addr = PAW'(log_addr);
        end else begin
            phys_addr = PAW'(NGLOB + lin);
        end
    end

endmodule

// File: rtl/rwf_window_ctrl.sv
// Window pointer and nesting-depth state machine.
module rwf_window_ctrl
    import rwf_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int CWPW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_req,
    input  logic            ret_req,
    output logic [CWPW-1:0] cwp,
    output logic [CWPW-1:0] depth,
    output logic            overflow,
    output logic            underflow
);
    localparam logic [CWPW-1:0] LAST = CWPW'(NWIN - 1);
    localparam logic [CWPW-1:0] ONE  = CWPW'(1);

    win_state_e      state_q, state_n;
    logic [CWPW-1:0] cwp_q, cwp_n;
    logic [CWPW-1:0] depth_q, depth_n;
    logic            ovf_set, unf_set;
    logic            do_call, do_ret;

    assign do_call = call_req && !ret_req;
    assign do_ret  = ret_req && !call_req;

    // Next-state logic
    always_comb begin
        state_n = state_q;
        cwp_n   = cwp_q;
        depth_n = depth_q;
        ovf_set = 1'b0;
        unf_set = 1'b0;
        unique case (state_q)
            WIN_ROOT: begin
                if (do_call) begin
                    cwp_n   = (cwp_q == LAST) ? '0 : cwp_q + ONE;
                    depth_n = ONE;
                    state_n = (ONE == LAST) ? WIN_FULL : WIN_NESTED;
                end else if (do_ret) begin
                    unf_set = 1'b1;
                end
            end
            WIN_NESTED: begin
                if (do_call) begin
                    cwp_n   = (cwp_q == LAST) ? '0 : cwp_q + ONE;
                    depth_n = depth_q + ONE;
                    state_n = (depth_q + ONE == LAST) ? WIN_FULL : WIN_NESTED;
                end else if (do_ret) begin
                    cwp_n   = (cwp_q == '0) ? LAST : cwp_q - ONE;
                    depth_n = depth_q - ONE;
                    state_n = (depth_q == ONE) ? WIN_ROOT : WIN_NESTED;
                end
            end
            WIN_FULL: begin
                if (do_call) begin
                    ovf_set = 1'b1;
                end else if (do_ret) begin
                    cwp_n   = (cwp_q == '0) ? LAST : cwp_q - ONE;
                    depth_n = depth_q - ONE;
                    state_n = (depth_q == ONE) ? WIN_ROOT : WIN_NESTED;
                end
            end
            default: begin
                state_n = WIN_ROOT;
                cwp_n   = '0;
                depth_n = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIN_ROOT;
            cwp_q   <= '0;
            depth_q <= '0;
        end else begin
            state_q <= state_n;
            cwp_q   <= cwp_n;
            depth_q <= depth_n;
        end
    end

    // Output register: one-cycle refusal flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            overflow  <= ovf_set;
            underflow <= unf_set;
        end
    end

    assign cwp   = cwp_q;
    assign depth = depth_q;

endmodule

// File: rtl/rwf_regbank.sv
// Physical storage: entry 0 is constant zero, the rest are flops.
module rwf_regbank #(
    parameter int NPHYS = 74,
    parameter int PAW   = 7,
    parameter int DW    = 32,
    parameter int NRD   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [PAW-1:0] wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [PAW-1:0] rd_addr [NRD],
    output logic [DW-1:0]  rd_data [NRD]
);
    localparam int NCELL = NPHYS - 1;

    logic [DW-1:0] cells [NCELL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCELL; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NCELL; i++) begin
                if (wr_addr == PAW'(i + 1)) begin
                    cells[i] <= wr_data;
                end
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            rd_data[p] = '0;
            for (int i = 0; i < NCELL; i++) begin
                if (rd_addr[p] == PAW'(i + 1)) begin
                    rd_data[p] = cells[i];
                end
            end
        end
    end

endmodule

// File: rtl/regwin_file.sv
// Overlapped register window file: top level.
module regwin_file
    import rwf_pkg::*;
#(
    parameter int NGLOB   = 10,
    parameter int NLOCAL  = 10,
    parameter int NCOMMON = 6,
    parameter int NWIN    = 4,
    parameter int DW      = 32,
    localparam int NLOG   = NGLOB + NLOCAL + 2 * NCOMMON,
    localparam int LAW    = $clog2(NLOG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [LAW-1:0] rd_addr_a,
    output logic [DW-1:0]  rd_data_a,
    input  logic [LAW-1:0] rd_addr_b,
    output logic [DW-1:0]  rd_data_b,
    input  logic           wr_en,
    input  logic [LAW-1:0] wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic           call_req,
    input  logic           ret_req,
    output logic           overflow,
    output logic           underflow
);
    localparam int RING  = (NLOCAL + NCOMMON) * NWIN;
    localparam int NPHYS = RING + NGLOB;
    localparam int PAW   = $clog2(NPHYS);
    localparam int CWPW  = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam int NRD   = 2;

    logic [CWPW-1:0] cwp;
    logic [CWPW-1:0] depth;
    logic [LAW-1:0]  log_rd  [NRD];
    logic [PAW-1:0]  phys_rd [NRD];
    logic [DW-1:0]   data_rd [NRD];
    logic [PAW-1:0]  phys_wr;
    logic            wr_live;

    assign log_rd[0] = rd_addr_a;
    assign log_rd[1] = rd_addr_b;
    assign rd_data_a = data_rd[0];
    assign rd_data_b = data_rd[1];

    // R0 writes are dropped before they reach storage
    assign wr_live = wr_en && (wr_addr != '0);

    rwf_window_ctrl #(
        .NWIN (NWIN),
        .CWPW (CWPW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .call_req  (call_req),
        .ret_req   (ret_req),
        .cwp       (cwp),
        .depth     (depth),
        .overflow  (overflow),
        .underflow (underflow)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rmap
        rwf_addr_map #(
            .NGLOB   (NGLOB),
            .NLOCAL  (NLOCAL),
            .NCOMMON (NCOMMON),
            .NWIN    (NWIN),
            .LAW     (LAW),
            .PAW     (PAW),
            .CWPW    (CWPW)
        ) u_map (
            .log_addr  (log_rd[p]),
            .cwp       (cwp),
            .phys_addr (phys_rd[p])
        );
    end

    rwf_addr_map #(
        .NGLOB   (NGLOB),
        .NLOCAL  (NLOCAL),
        .NCOMMON (NCOMMON),
        .NWIN    (NWIN),
        .LAW     (LAW),
        .PAW     (PAW),
        .CWPW    (CWPW)
    ) u_wmap (
        .log_addr  (wr_addr),
        .cwp       (cwp),
        .phys_addr (phys_wr)
    );

    rwf_regbank #(
        .NPHYS (NPHYS),
        .PAW   (PAW),
        .DW    (DW),
        .NRD   (NRD)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_live),
        .wr_addr (phys_wr),
        .wr_data (wr_data),
        .rd_addr (phys_rd),
        .rd_data (data_rd)
    );

endmodule

// File: rtl/regwin_file_chk.sv
// Property checker bound to the window file.
module regwin_file_chk #(
    parameter int NWIN = 4,
    parameter int CWPW = 2,
    parameter int LAW  = 5,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [LAW-1:0]  rd_addr_a,
    input logic [DW-1:0]   rd_data_a,
    input logic [LAW-1:0]  rd_addr_b,
    input logic [DW-1:0]   rd_data_b,
    input logic            call_req,
    input logic            ret_req,
    input logic            overflow,
    input logic            underflow,
    input logic [CWPW-1:0] cwp,
    input logic [CWPW-1:0] depth
);
    localparam logic [CWPW-1:0] LAST = CWPW'(NWIN - 1);

    // R7: accepted call advances pointer and depth
    a_r7_call_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !ret_req && depth != LAST) |=>
            (cwp == (($past(cwp) == LAST) ? '0 : $past(cwp) + 1'b1)) &&
            (depth == $past(depth) + 1'b1));

    // R7: accepted return moves pointer back
    a_r7_ret_retreat: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !call_req && depth != '0) |=>
            (cwp == (($past(cwp) == '0) ? LAST : $past(cwp) - 1'b1)) &&
            (depth == $past(depth) - 1'b1));

    // R8: refused call
    a_r8_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !ret_req && depth == LAST) |=>
            overflow && $stable(cwp) && $stable(depth));

    // R9: refused return
    a_r9_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !call_req && depth == '0) |=>
            underflow && $stable(cwp) && $stable(depth));

    // R11: simultaneous requests cancel
    a_r11_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && ret_req) |=>
            $stable(cwp) && $stable(depth) && !overflow && !underflow);

    // R5: register zero reads zero on both ports
    a_r5_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |-> (rd_data_a == '0));
    a_r5_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b == '0) |-> (rd_data_b == '0));

    // R8/R9: flags never both set
    a_r8_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow));

endmodule

bind regwin_file regwin_file_chk #(
    .NWIN (NWIN),
    .CWPW (CWPW),
    .LAW  (LAW),
    .DW   (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_a (rd_addr_a),
    .rd_data_a (rd_data_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_b (rd_data_b),
    .call_req  (call_req),
    .ret_req   (ret_req),
    .overflow  (overflow),
    .underflow (underflow),
    .cwp       (cwp),
    .depth     (depth)
);

// File: tb/regwin_file_bench.sv
module regwin_file_bench;

    localparam int G  = 10;
    localparam int L  = 10;
    localparam int C  = 6;
    localparam int W  = 4;
    localparam int DW = 32;
    localparam int NP = (L + C) * W + G;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    rd_addr_a = '0;
    logic [DW-1:0] rd_data_a;
    logic [4:0]    rd_addr_b = '0;
    logic [DW-1:0] rd_data_b;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          call_req = 1'b0;
    logic          ret_req = 1'b0;
    logic          overflow;
    logic          underflow;

    int n_chk = 0;
    int n_bad = 0;

    // Behavioural reference state
    logic [DW-1:0] m_mem [NP];
    int            m_cwp = 0;
    int            m_depth = 0;
    bit            m_ovf = 1'b0;
    bit            m_unf = 1'b0;

    regwin_file u_regwin_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_a (rd_addr_a),
        .rd_data_a (rd_data_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_b (rd_data_b),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .call_req  (call_req),
        .ret_req   (ret_req),
        .overflow  (overflow),
        .underflow (underflow)
    );

    always #2 clk = ~clk;

    function automatic int mphys(input int r, input int w);
        if (r < G) return r;
        return G + ((w * (L + C) + r - G) % ((L + C) * W));
    endfunction

    function automatic logic [DW-1:0] mread(input int r);
        if (r == 0) return '0;
        return m_mem[mphys(r, m_cwp)];
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h (cwp=%0d depth=%0d)",
                     tag, what, act, exp, m_cwp, m_depth);
        end
    endtask

    // One clock: drive, check combinational reads and flags, update model
    task automatic step(input string tag, input bit we, input int wa,
                        input logic [DW-1:0] wd, input int ra, input int rb,
                        input bit c, input bit r);
        @(negedge clk);
        wr_en     = we;
        wr_addr   = 5'(wa);
        wr_data   = wd;
        rd_addr_a = 5'(ra);
        rd_addr_b = 5'(rb);
        call_req  = c;
        ret_req   = r;
        #1;
        check(tag, "rd_data_a", rd_data_a, mread(ra));
        check(tag, "rd_data_b", rd_data_b, mread(rb));
        check(tag, "overflow",  DW'(overflow),  DW'(m_ovf));
        check(tag, "underflow", DW'(underflow), DW'(m_unf));
        @(posedge clk);
        if (we && wa != 0) m_mem[mphys(wa, m_cwp)] = wd;
        m_ovf = 1'b0;
        m_unf = 1'b0;
        if (c && !r) begin
            if (m_depth == W - 1) m_ovf = 1'b1;
            else begin m_depth++; m_cwp = (m_cwp + 1) % W; end
        end else if (r && !c) begin
            if (m_depth == 0) m_unf = 1'b1;
            else begin m_depth--; m_cwp = (m_cwp + W - 1) % W; end
        end
    endtask

    task automatic idle(input string tag, input int ra, input int rb);
        step(tag, 1'b0, 0, '0, ra, rb, 1'b0, 1'b0);
    endtask

    task automatic wr(input string tag, input int a, input logic [DW-1:0] d);
        step(tag, 1'b1, a, d, a, 0, 1'b0, 1'b0);
    endtask

    // Watchdog
    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        idle("R1", 0, 5);
        idle("R1", 17, 31);
        idle("R1", 10, 26);
        idle("R1", 9, 25);

        // R5: R0 write ignored
        wr("R5", 0, 32'hDEAD_BEEF);
        idle("R5", 0, 0);

        // R2: globals shared across windows
        for (int i = 1; i < G; i++) wr("R2", i, 32'h100 + i);
        step("R7", 1'b0, 0, '0, 1, 2, 1'b1, 1'b0);
        for (int i = 1; i < G; i++) idle("R2", i, G - i);
        wr("R2", 4, 32'hABC);
        step("R7", 1'b0, 0, '0, 4, 3, 1'b0, 1'b1);
        idle("R2", 4, 3);

        // Fill windows 0..3, calling down
        for (int w = 0; w < W; w++) begin
            for (int r = 16; r < 32; r++) wr("R4", r, 32'h1000 * (w + 1) + r);
            if (w > 0) for (int r = 10; r < 16; r++) idle("R3", r, r + 16);
            if (w < W - 1) step("R7", 1'b0, 0, '0, 16, 26, 1'b1, 1'b0);
        end
        // R8: refused call at depth 3
        step("R8", 1'b0, 0, '0, 10, 31, 1'b1, 1'b0);
        idle("R8", 16, 26);
        idle("R8", 25, 30);

        // Return up, checking locals and shared groups
        for (int w = W - 1; w > 0; w--) begin
            step("R7", 1'b0, 0, '0, 20, 28, 1'b0, 1'b1);
            for (int r = 16; r < 26; r++) idle("R4", r, r + 6);
            for (int r = 26; r < 32; r++) idle("R3", r, r - 16);
        end
        // R6: window 0 incoming = window 3 outgoing
        for (int r = 10; r < 16; r++) idle("R6", r, r + 16);

        // R9: refused return at depth 0
        step("R9", 1'b0, 0, '0, 10, 16, 1'b0, 1'b1);
        idle("R9", 11, 17);
        idle("R9", 12, 18);

        // R10: write with call uses the old window
        step("R10", 1'b1, 20, 32'h55, 20, 0, 1'b1, 1'b0);
        idle("R10", 20, 10);
        step("R10", 1'b1, 12, 32'h77, 12, 20, 1'b0, 1'b1);
        idle("R10", 20, 28);
        idle("R10", 12, 28);

        // R11: call and return together
        step("R11", 1'b0, 0, '0, 20, 0, 1'b1, 1'b1);
        idle("R11", 20, 28);
        step("R7", 1'b0, 0, '0, 20, 0, 1'b1, 1'b0);
        step("R11", 1'b1, 17, 32'h99, 17, 20, 1'b1, 1'b1);
        idle("R11", 17, 20);
        step("R7", 1'b0, 0, '0, 20, 0, 1'b0, 1'b1);
        idle("R11", 17, 20);

        // R12: random traffic on all ports
        for (int n = 0; n < 4000; n++) begin
            int k;
            bit c, r;
            k = int'($urandom % 10);
            c = (k == 0);
            r = (k == 1);
            if (k == 2) begin c = 1'b1; r = 1'b1; end
            step("R12", bit'($urandom % 2), int'($urandom % 32), $urandom,
                 int'($urandom % 32), int'($urandom % 32), c, r);
        end
        idle("R12", 0, 31);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule